// File: doc/BRIEF.md
# Green Mode Burst Controller

This block decides, once per master PWM switching period, how a combined boost power-factor stage and the PWM stage after it should run under light load. On each period strobe it takes two ADC readings: the duty-command voltage of the PWM stage and the scaled feedback of the boost bus. From these readings it drives three outputs. The first enables the PFC stage. The second permits or suppresses the PWM pulse for the coming period. The third flags low-power operation. A fourth output is a one-cycle request that starts a PFC soft start each time the PFC stage is switched back on.

A duty command below an entry threshold moves the block into low-power operation. There the PFC stage is off and a PWM pulse is allowed only when the duty command reaches a higher skip threshold. The result is pulse skipping aligned to the switching clock. When the bus feedback sags below a low bus threshold, the PFC stage runs a recharge burst. During the burst the duty command is compared against the entry threshold, and this is the only point at which low-power operation can be left. The burst ends once the bus feedback climbs above a high bus threshold. All four thresholds are input codes in the same scale as the readings.

Top module: `green_burst_ctrl`

## Requirements
- R1: After reset the outputs read pfcEnable=1, pulsePermit=1, greenMode=0, softStartReq=0.
- R2: Inputs are sampled only on a clock edge where periodStrobe=1. The outputs take their new values on that edge and hold them on every edge where periodStrobe=0, whatever the readings do.
- R3: In continuous operation, a strobe with dutyCode < enterThr sets greenMode=1 and pfcEnable=0, with pulsePermit=(dutyCode >= skipThr). Any other strobe keeps pfcEnable=1 and greenMode=0 and sets pulsePermit=1.
- R4: While skipping (greenMode=1, pfcEnable=0), a strobe with busCode >= busLowThr sets pulsePermit=(dutyCode >= skipThr). pfcEnable and greenMode do not change.
- R5: While skipping, a strobe with busCode < busLowThr starts a burst: pfcEnable=1, greenMode=0, pulsePermit=(dutyCode >= enterThr).
- R6: During a burst, a strobe with dutyCode >= enterThr returns the block to continuous operation: pfcEnable=1, greenMode=0, pulsePermit=1.
- R7: During a burst, a strobe with dutyCode < enterThr sets greenMode=1. If busCode > busHighThr it also sets pfcEnable=0 and pulsePermit=(dutyCode >= skipThr) and skipping resumes. Otherwise pfcEnable stays 1, pulsePermit=0 and the burst continues.
- R8: softStartReq is high for exactly one clock, on the same edge where pfcEnable goes from 0 to 1, and at no other time.
- R9: All comparisons are unsigned. "Below" and "above" are strict. The duty comparison for a permitted pulse is inclusive (a reading equal to the threshold counts as reaching it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodStrobe | input | 1 | One-clock pulse at the start of each master PWM period |
| dutyCode | input | ADC_W | Digitized PWM duty-command reading |
| busCode | input | ADC_W | Digitized boost-bus feedback reading |
| enterThr | input | ADC_W | Duty level below which low-power operation is entered |
| skipThr | input | ADC_W | Duty level a reading must reach for a pulse while skipping |
| busLowThr | input | ADC_W | Bus level below which a recharge burst starts |
| busHighThr | input | ADC_W | Bus level above which a recharge burst stops |
| pfcEnable | output | 1 | PFC stage enable |
| pulsePermit | output | 1 | PWM pulse allowed in the current period |
| greenMode | output | 1 | Low-power operation flag |
| softStartReq | output | 1 | One-clock PFC soft start request |

## Verification
The hardest situation to reach from the ports is the end of a burst in which the duty command stayed below the entry threshold the whole time. It needs a precise sequence: enter skipping, let the bus sag below the low threshold, hold the duty command low while the bus stays between the two thresholds, and then raise the bus past the high threshold. The bench builds this sequence directly and also builds the one where the duty command recovers in mid-burst. Readings equal to each threshold are applied in those scripted sequences. After that, random readings centred on the thresholds drive thousands of strobes so the block cycles through the skip-burst loop repeatedly. Random readings also change between strobes to test that they are ignored.

// File: rtl/green_burst_pkg.sv
package green_burst_pkg;

  typedef enum logic [1:0] {
    MODE_CONT  = 2'd0,
    MODE_SKIP  = 2'd1,
    MODE_BURST = 2'd2
  } modeT;

  typedef enum logic [1:0] {
    PERMIT_ALL   = 2'd0,
    PERMIT_SKIP  = 2'd1,
    PERMIT_ENTER = 2'd2
  } permitSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    permitSelT permitSel;
    logic      pfcOn;
    logic      green;
  } ctlT;

  // comparator results from datapath to control
  typedef struct packed {
    logic dutyBelowEnter;
    logic busBelowLow;
    logic busAboveHigh;
  } cmpT;

endpackage

// File: rtl/green_burst_fsm.sv
module green_burst_fsm
  import green_burst_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic periodStrobe,
  input  cmpT  cmp,
  output ctlT  ctl
);

  modeT mode;
  modeT modeNext;

  always_comb begin
    ctl           = '0;
    ctl.load      = periodStrobe;
    ctl.permitSel = PERMIT_ALL;
    ctl.pfcOn     = 1'b1;
    ctl.green     = 1'b0;
    modeNext      = mode;
    unique case (mode)
      MODE_CONT: begin
        if (cmp.dutyBelowEnter) begin
          modeNext      = MODE_SKIP;
          ctl.pfcOn     = 1'b0;
          ctl.green     = 1'b1;
          ctl.permitSel = PERMIT_SKIP;
        end
      end
      MODE_SKIP: begin
        if (cmp.busBelowLow) begin
          modeNext      = MODE_BURST;
          ctl.permitSel = PERMIT_ENTER;
        end else begin
          ctl.pfcOn     = 1'b0;
          ctl.green     = 1'b1;
          ctl.permitSel = PERMIT_SKIP;
        end
      end
      MODE_BURST: begin
        if (!cmp.dutyBelowEnter) begin
          modeNext = MODE_CONT;
        end else if (cmp.busAboveHigh) begin
          modeNext      = MODE_SKIP;
          ctl.pfcOn     = 1'b0;
          ctl.green     = 1'b1;
          ctl.permitSel = PERMIT_SKIP;
        end else begin
          ctl.green     = 1'b1;
          ctl.permitSel = PERMIT_ENTER;
        end
      end
      default: modeNext = MODE_CONT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             mode <= MODE_CONT;
    else if (periodStrobe) mode <= modeNext;
  end

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(periodStrobe) |-> $stable(mode));

  // R5
  burst_from_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BURST && $past(mode) != MODE_BURST) |-> $past(mode) == MODE_SKIP);

  // R6
  cont_from_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MODE_BURST && mode == MODE_CONT) |-> !$past(cmp.dutyBelowEnter));

endmodule

// File: rtl/green_burst_dp.sv
module green_burst_dp
  import green_burst_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ADC_W-1:0] dutyCode,
  input  logic [ADC_W-1:0] busCode,
  input  logic [ADC_W-1:0] enterThr,
  input  logic [ADC_W-1:0] skipThr,
  input  logic [ADC_W-1:0] busLowThr,
  input  logic [ADC_W-1:0] busHighThr,
  input  ctlT              ctl,
  output cmpT              cmp,
  output logic             pfcEnable,
  output logic             pulsePermit,
  output logic             greenMode,
  output logic             softStartReq
);

  logic dutyAtSkip;
  logic permitNext;

  always_comb begin
    cmp.dutyBelowEnter = dutyCode < enterThr;
    cmp.busBelowLow    = busCode < busLowThr;
    cmp.busAboveHigh   = busCode > busHighThr;
    dutyAtSkip         = dutyCode >= skipThr;
  end

  always_comb begin
    unique case (ctl.permitSel)
      PERMIT_SKIP:  permitNext = dutyAtSkip;
      PERMIT_ENTER: permitNext = !cmp.dutyBelowEnter;
      default:      permitNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfcEnable    <= 1'b1;
      pulsePermit  <= 1'b1;
      greenMode    <= 1'b0;
      softStartReq <= 1'b0;
    end else begin
      softStartReq <= ctl.load && ctl.pfcOn && !pfcEnable;
      if (ctl.load) begin
        pfcEnable   <= ctl.pfcOn;
        pulsePermit <= permitNext;
        greenMode   <= ctl.green;
      end
    end
  end

  // R8
  soft_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfcEnable) |-> softStartReq);

  // R8
  soft_only_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    softStartReq |-> $rose(pfcEnable));

  // R4
  skip_permit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.load) && greenMode && !pfcEnable) |->
      pulsePermit == ($past(dutyCode) >= $past(skipThr)));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.load) |-> ($stable(pfcEnable) && $stable(pulsePermit) && $stable(greenMode)));

  // R5
  pfc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfcEnable) |-> ($past(greenMode) && !greenMode));

endmodule

// File: rtl/green_burst_ctrl.sv
module green_burst_ctrl
  import green_burst_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             periodStrobe,
  input  logic [ADC_W-1:0] dutyCode,
  input  logic [ADC_W-1:0] busCode,
  input  logic [ADC_W-1:0] enterThr,
  input  logic [ADC_W-1:0] skipThr,
  input  logic [ADC_W-1:0] busLowThr,
  input  logic [ADC_W-1:0] busHighThr,
  output logic             pfcEnable,
  output logic             pulsePermit,
  output logic             greenMode,
  output logic             softStartReq
);

  ctlT ctl;
  cmpT cmp;

  green_burst_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .periodStrobe (periodStrobe),
    .cmp          (cmp),
    .ctl          (ctl)
  );

  green_burst_dp #(.ADC_W(ADC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dutyCode     (dutyCode),
    .busCode      (busCode),
    .enterThr     (enterThr),
    .skipThr      (skipThr),
    .busLowThr    (busLowThr),
    .busHighThr   (busHighThr),
    .ctl          (ctl),
    .cmp          (cmp),
    .pfcEnable    (pfcEnable),
    .pulsePermit  (pulsePermit),
    .greenMode    (greenMode),
    .softStartReq (softStartReq)
  );

endmodule

// File: tb/green_burst_ctrl_bench.sv
module green_burst_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADC_W = 10;
  localparam logic [ADC_W-1:0] ENTER = 10'd266;
  localparam logic [ADC_W-1:0] SKIP  = 10'd323;
  localparam logic [ADC_W-1:0] BLOW  = 10'd460;
  localparam logic [ADC_W-1:0] BHIGH = 10'd512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic periodStrobe = 1'b0;
  logic [ADC_W-1:0] dutyCode = '0;
  logic [ADC_W-1:0] busCode = '0;
  logic pfcEnable, pulsePermit, greenMode, softStartReq;

  int total = 0;
  int bad = 0;

  // bench model: 0 continuous, 1 skipping, 2 burst
  int  mMode = 0;
  logic mPfc = 1'b1, mPermit = 1'b1, mGreen = 1'b0, mSoft = 1'b0;
  string mTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  green_burst_ctrl #(.ADC_W(ADC_W)) u_green_burst_ctrl (
    .clk(clk), .rstN(rstN), .periodStrobe(periodStrobe),
    .dutyCode(dutyCode), .busCode(busCode),
    .enterThr(ENTER), .skipThr(SKIP), .busLowThr(BLOW), .busHighThr(BHIGH),
    .pfcEnable(pfcEnable), .pulsePermit(pulsePermit),
    .greenMode(greenMode), .softStartReq(softStartReq)
  );

  task automatic check1(input string tag, input string name, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    check1(mTag, "pfcEnable", pfcEnable, mPfc);
    check1(mTag, "pulsePermit", pulsePermit, mPermit);
    check1(mTag, "greenMode", greenMode, mGreen);
    check1("R8", "softStartReq", softStartReq, mSoft);
  endtask

  // next-state rule from R3..R7, comparisons per R9
  task automatic modelStep(input logic [ADC_W-1:0] d, input logic [ADC_W-1:0] b);
    logic below;
    logic oldPfc;
    below  = d < ENTER;
    oldPfc = mPfc;
    case (mMode)
      0: begin
        mTag = "R3";
        if (below) begin mMode = 1; mPfc = 0; mGreen = 1; mPermit = d >= SKIP; end
        else begin mPfc = 1; mGreen = 0; mPermit = 1; end
      end
      1: begin
        if (b < BLOW) begin mTag = "R5"; mMode = 2; mPfc = 1; mGreen = 0; mPermit = !below; end
        else begin mTag = "R4"; mPermit = d >= SKIP; end
      end
      default: begin
        if (!below) begin mTag = "R6"; mMode = 0; mPfc = 1; mGreen = 0; mPermit = 1; end
        else if (b > BHIGH) begin mTag = "R7"; mMode = 1; mPfc = 0; mGreen = 1; mPermit = d >= SKIP; end
        else begin mTag = "R7"; mPfc = 1; mGreen = 1; mPermit = 0; end
      end
    endcase
    mSoft = mPfc && !oldPfc;
  endtask

  // called at a negedge: drive, let one edge pass, check at the next negedge
  task automatic strobeStep(input logic [ADC_W-1:0] d, input logic [ADC_W-1:0] b);
    dutyCode = d; busCode = b; periodStrobe = 1'b1;
    modelStep(d, b);
    @(negedge clk);
    periodStrobe = 1'b0;
    checkAll();
  endtask

  // R2: readings move without a strobe; outputs must hold
  task automatic idleStep(input logic [ADC_W-1:0] d, input logic [ADC_W-1:0] b);
    dutyCode = d; busCode = b; periodStrobe = 1'b0;
    mSoft = 1'b0;
    mTag = "R2";
    @(negedge clk);
    checkAll();
  endtask

  function automatic logic [ADC_W-1:0] randDuty();
    return 10'(200 + ($urandom % 180));
  endfunction

  function automatic logic [ADC_W-1:0] randBus();
    return 10'(420 + ($urandom % 130));
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mTag = "R1";
    checkAll();

    // continuous with duty exactly at enter (R9: not below) -> stay
    strobeStep(ENTER, 10'd500);
    // enter skipping (R3)
    strobeStep(ENTER - 1, 10'd500);
    idleStep(10'd600, 10'd100);
    idleStep(10'd0, 10'd0);
    // skip: duty exactly at skip threshold permits (R9, R4)
    strobeStep(SKIP, 10'd500);
    strobeStep(SKIP - 1, 10'd500);
    // bus exactly at low threshold does not start a burst (R9)
    strobeStep(10'd100, BLOW);
    // burst start (R5), duty low
    strobeStep(10'd100, BLOW - 1);
    idleStep(10'd400, 10'd600);
    // burst continues, bus exactly at high threshold (R7)
    strobeStep(10'd100, BHIGH);
    // burst ends above high threshold (R7)
    strobeStep(10'd100, BHIGH + 1);
    // second restart must request soft start again (R8)
    strobeStep(10'd100, 10'd300);
    // duty recovers mid-burst -> continuous (R6)
    strobeStep(ENTER, 10'd480);
    strobeStep(10'd50, 10'd480);

    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 3) == 0) idleStep(randDuty(), randBus());
      else strobeStep(randDuty(), randBus());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule